// File: doc/BRIEF.md
# Two-stage watchdog timer

This block is a memory-mapped watchdog with a plain register write/read port, a free-running tick input and four plain outputs. Once software enables it, a down-counter loads the first-stage preload and decrements once per prescaled tick. When the first stage runs out, the block issues the first-stage action chosen in the control register: a normal interrupt pulse, a system-management pulse, or nothing. It then reloads the counter from the second-stage preload. When the second stage runs out, it either restarts the first stage (free-run mode), or pulses a reset request and sets a sticky timeout flag, or stops quietly when the reset action is switched off.

The preload and reload registers are guarded by a two-write key sequence, and each accepted guarded write uses up the key. A lock bit, once set, freezes the enable bit until the next reset. The timeout flag survives the block's synchronous reset, so software can find out after a restart that the watchdog caused it. The register port has no back-pressure: every write is taken in the cycle `wr_valid` is high, and reads are combinational from `rd_addr`.

Top module: `wdog_two_stage`

## Requirements
- R1: After synchronous reset both preloads read 0xFFFFF, control (offset 0x10) and lock (offset 0x14) read 0, and the three pulse outputs are low. The timeout flag keeps its value through reset.
- R2: Offsets 0x00, 0x04 and 0x0C are guarded. A write of exactly 0x80 to 0x0C arms the key. A following write of exactly 0x86 to 0x0C, taken only while armed, opens it. A guarded write takes effect only while the key is open. The first guarded write that takes effect closes the key again. Guarded writes at any other time change nothing.
- R3: Preload 1 (offset 0x00) and preload 2 (offset 0x04) keep only bits 19:0 of the written word.
- R4: Lock register bit 1 is enable. Raising it starts stage 1 with preload 1 and a cleared prescaler. Control bit 2 selects the FAST_DIV tick divider; a 0 selects SLOW_DIV. Stage 1 ends on the (P1+1)-th prescaled tick, so with a tick in every cycle the stage-1 action appears (P1+1)*div cycles after the enabling write.
- R5: At the end of stage 1, control bits 1:0 choose the action: 0 pulses `irq_pulse`, 2 pulses `smi_pulse`, 1 and 3 pulse nothing. The counter then loads preload 2, and stage 2 ends (P2+1)*div cycles later.
- R6: If stage 2 ends with free-run off and control bit 5 clear, `reset_req` pulses and `prev_timeout` goes high on the next cycle. The counter then halts.
- R7: Control bit 5 set turns the reset action off. Stage 2 then ends without a reset request and without setting the flag, and the counter halts.
- R8: Lock register bit 2 is free-run. With it set, the end of stage 2 restarts stage 1 from preload 1, and no reset request is issued.
- R9: A taken write to 0x0C with bit 8 set, while enabled, restarts stage 1 from preload 1 with a cleared prescaler.
- R10: A taken write to 0x0C with bit 9 or bit 12 set clears the timeout flag. The status register at 0x08 reads 0x1200 while the flag is set and 0 while it is clear.
- R11: Lock register bit 0 is sticky until reset. While it is set, writes cannot change enable. Clearing enable while unlocked halts the counter, so no further action follows.
- R12: `irq_pulse`, `smi_pulse` and `reset_req` last one cycle each, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high (timeout flag excluded) |
| wr_valid | input | 1 | Register write strobe, taken in the same cycle |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte offset of the combinational read |
| rd_data | output | DATA_W | Read data for `rd_addr` |
| tick_in | input | 1 | Time-base tick, one cycle per tick |
| irq_pulse | output | 1 | Stage-1 normal interrupt pulse |
| smi_pulse | output | 1 | Stage-1 system-management pulse |
| reset_req | output | 1 | Stage-2 reset request pulse |
| prev_timeout | output | 1 | Sticky flag: a reset request has been issued |

## Verification
A table of configurations runs each stage-1 action type against both tick dividers, with the reset action on and off, with free-run on and off, and with preloads of zero and above zero. Measuring the cycle of the first pulse and counting pulses over a fixed window separates errors in the preload-plus-one count, divider selection, stage-2 loading and free-run restart. Directed cases send key sequences in the wrong order, replay a guarded write after the key is used up, send a refresh in the middle of stage 1, try to clear enable while locked, disable before expiry, and reset while the flag is set. Each of these changes a register readback or a pulse time in its own way.

// File: rtl/wdt2_pkg.sv
`timescale 1ns/1ps
package wdt2_pkg;

  // register byte offsets; software decodes these
  localparam int OFS_PRE1 = 'h00;
  localparam int OFS_PRE2 = 'h04;
  localparam int OFS_STAT = 'h08;
  localparam int OFS_KICK = 'h0C;
  localparam int OFS_CTRL = 'h10;
  localparam int OFS_LOCK = 'h14;

  localparam logic [31:0] KEY_ARM  = 32'h0000_0080;
  localparam logic [31:0] KEY_OPEN = 32'h0000_0086;
  localparam logic [31:0] STAT_SET = 32'h0000_1200;

  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_ARMED = 2'd1,
    KEY_READY = 2'd2
  } key_state_e;

  typedef enum logic [1:0] {
    STG_IDLE = 2'd0,
    STG_ONE  = 2'd1,
    STG_TWO  = 2'd2
  } stage_e;

  localparam logic [1:0] ACT_IRQ = 2'd0;
  localparam logic [1:0] ACT_SMI = 2'd2;

endpackage

// File: rtl/wdt2_keyfsm.sv
`timescale 1ns/1ps
module wdt2_keyfsm
  import wdt2_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              key_open,
  output logic              accept
);

  key_state_e state_q;
  logic is_kick, is_guarded, arm_hit, open_hit;

  always_comb begin
    is_kick    = (wr_addr == ADDR_W'(OFS_KICK));
    is_guarded = is_kick || (wr_addr == ADDR_W'(OFS_PRE1)) ||
                 (wr_addr == ADDR_W'(OFS_PRE2));
    arm_hit    = wr_valid && is_kick && (wr_data == DATA_W'(KEY_ARM));
    open_hit   = wr_valid && is_kick && (wr_data == DATA_W'(KEY_OPEN)) &&
                 (state_q == KEY_ARMED);
    accept     = wr_valid && is_guarded && !arm_hit && !open_hit &&
                 (state_q == KEY_READY);
    key_open   = (state_q == KEY_READY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KEY_IDLE;
    end else if (arm_hit) begin
      state_q <= KEY_ARMED;
    end else if (open_hit) begin
      state_q <= KEY_READY;
    end else if (accept) begin
      state_q <= KEY_IDLE;
    end
  end

endmodule

// File: rtl/wdt2_prescale.sv
`timescale 1ns/1ps
module wdt2_prescale #(
  parameter int SLOW_DIV = 8,
  parameter int FAST_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic fast,
  input  logic tick_in,
  output logic step
);

  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int PW      = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  generate
    if (MAX_DIV == 1) begin : g_pass
      assign step = tick_in;
      logic unused_in;
      assign unused_in = clk ^ rst ^ clear ^ fast;
    end else begin : g_count
      localparam logic [PW-1:0] SLOW_LIM = PW'(SLOW_DIV - 1);
      localparam logic [PW-1:0] FAST_LIM = PW'(FAST_DIV - 1);
      logic [PW-1:0] pcnt_q;
      logic [PW-1:0] lim;

      always_comb begin
        lim  = fast ? FAST_LIM : SLOW_LIM;
        step = tick_in && (pcnt_q >= lim);
      end

      always_ff @(posedge clk) begin
        if (rst || clear) begin
          pcnt_q <= '0;
        end else if (tick_in) begin
          pcnt_q <= step ? '0 : pcnt_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/wdt2_stager.sv
`timescale 1ns/1ps
module wdt2_stager
  import wdt2_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic             step,
  input  logic [CNT_W-1:0] pre1,
  input  logic [CNT_W-1:0] pre2,
  input  logic [1:0]       act_sel,
  input  logic             rst_off,
  input  logic             free_run,
  output logic             irq_o,
  output logic             smi_o,
  output logic             req_o
);

  stage_e           stage_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= STG_IDLE;
      cnt_q   <= '0;
      irq_o   <= 1'b0;
      smi_o   <= 1'b0;
      req_o   <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      smi_o <= 1'b0;
      req_o <= 1'b0;
      if (stop) begin
        stage_q <= STG_IDLE;
      end else if (start) begin
        stage_q <= STG_ONE;
        cnt_q   <= pre1;
      end else if (step && (stage_q != STG_IDLE)) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (stage_q == STG_ONE) begin
          irq_o   <= (act_sel == ACT_IRQ);
          smi_o   <= (act_sel == ACT_SMI);
          stage_q <= STG_TWO;
          cnt_q   <= pre2;
        end else if (free_run) begin
          stage_q <= STG_ONE;
          cnt_q   <= pre1;
        end else begin
          req_o   <= !rst_off;
          stage_q <= STG_IDLE;
        end
      end
    end
  end

endmodule

// File: rtl/wdog_two_stage.sv
`timescale 1ns/1ps
module wdog_two_stage
  import wdt2_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 20,
  parameter int SLOW_DIV = 8,
  parameter int FAST_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick_in,
  output logic              irq_pulse,
  output logic              smi_pulse,
  output logic              reset_req,
  output logic              prev_timeout
);

  localparam logic [CNT_W-1:0] PRE_INIT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] pre1_q, pre2_q;
  logic [1:0]       ctl_act;
  logic             ctl_fast, ctl_rstoff;
  logic             lock_q, en_q, fr_q;
  logic             tmo_flag = 1'b0;

  logic key_open, accept;
  logic kick_take, lock_wr, ctrl_wr, en_free;
  logic start, stop, step, flag_clr;

  wdt2_keyfsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_keys (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .key_open(key_open), .accept(accept)
  );

  always_comb begin
    kick_take = accept && (wr_addr == ADDR_W'(OFS_KICK));
    lock_wr   = wr_valid && (wr_addr == ADDR_W'(OFS_LOCK));
    ctrl_wr   = wr_valid && (wr_addr == ADDR_W'(OFS_CTRL));
    en_free   = lock_wr && !lock_q;
    start     = (en_free && !en_q && wr_data[1]) ||
                (kick_take && wr_data[8] && en_q);
    stop      = en_free && !wr_data[1];
    flag_clr  = kick_take && (wr_data[9] || wr_data[12]);
  end

  // protected preloads
  always_ff @(posedge clk) begin
    if (rst) begin
      pre1_q <= PRE_INIT;
      pre2_q <= PRE_INIT;
    end else if (accept) begin
      if (wr_addr == ADDR_W'(OFS_PRE1)) pre1_q <= wr_data[CNT_W-1:0];
      if (wr_addr == ADDR_W'(OFS_PRE2)) pre2_q <= wr_data[CNT_W-1:0];
    end
  end

  // control and lock
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_act    <= 2'd0;
      ctl_fast   <= 1'b0;
      ctl_rstoff <= 1'b0;
      lock_q     <= 1'b0;
      en_q       <= 1'b0;
      fr_q       <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctl_act    <= wr_data[1:0];
        ctl_fast   <= wr_data[2];
        ctl_rstoff <= wr_data[5];
      end
      if (lock_wr) begin
        lock_q <= lock_q | wr_data[0];
        fr_q   <= wr_data[2];
        if (!lock_q) en_q <= wr_data[1];
      end
    end
  end

  wdt2_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
    .clk(clk), .rst(rst), .clear(start), .fast(ctl_fast),
    .tick_in(tick_in), .step(step)
  );

  wdt2_stager #(.CNT_W(CNT_W)) u_stage (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .step(step),
    .pre1(pre1_q), .pre2(pre2_q), .act_sel(ctl_act),
    .rst_off(ctl_rstoff), .free_run(fr_q),
    .irq_o(irq_pulse), .smi_o(smi_pulse), .req_o(reset_req)
  );

  // sticky flag: outside synchronous reset on purpose
  always_ff @(posedge clk) begin
    if (reset_req) begin
      tmo_flag <= 1'b1;
    end else if (flag_clr) begin
      tmo_flag <= 1'b0;
    end
  end

  assign prev_timeout = tmo_flag;

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADDR_W'(OFS_PRE1): rd_data = DATA_W'(pre1_q);
      ADDR_W'(OFS_PRE2): rd_data = DATA_W'(pre2_q);
      ADDR_W'(OFS_STAT): rd_data = tmo_flag ? DATA_W'(STAT_SET) : '0;
      ADDR_W'(OFS_CTRL): begin
        rd_data[1:0] = ctl_act;
        rd_data[2]   = ctl_fast;
        rd_data[5]   = ctl_rstoff;
      end
      ADDR_W'(OFS_LOCK): begin
        rd_data[0] = lock_q;
        rd_data[1] = en_q;
        rd_data[2] = fr_q;
      end
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/wdog_two_stage_chk.sv
`timescale 1ns/1ps
module wdog_two_stage_chk #(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              irq_pulse,
  input logic              smi_pulse,
  input logic              reset_req,
  input logic              prev_timeout,
  input logic              rst_off,
  input logic              free_run,
  input logic              lock_q,
  input logic              en_q,
  input logic              key_open,
  input logic [CNT_W-1:0]  pre1_q
);

  // R12
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_pulse, smi_pulse, reset_req}));

  // R12
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);

  // R6
  flag_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> prev_timeout);

  // R7
  req_needs_action_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> !$past(rst_off));

  // R8
  req_not_freerun_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> !$past(free_run));

  // R11
  lock_freezes_en_chk: assert property (@(posedge clk) disable iff (rst)
    $past(lock_q) |-> (en_q == $past(en_q)));

  // R2
  closed_key_pre_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && (wr_addr == '0) && !key_open) |=> $stable(pre1_q));

endmodule

bind wdog_two_stage wdog_two_stage_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .irq_pulse(irq_pulse), .smi_pulse(smi_pulse), .reset_req(reset_req),
  .prev_timeout(prev_timeout), .rst_off(ctl_rstoff), .free_run(fr_q),
  .lock_q(lock_q), .en_q(en_q), .key_open(key_open), .pre1_q(pre1_q)
);

// File: tb/wdog_two_stage_tb.sv
`timescale 1ns/1ps
module wdog_two_stage_tb;

  localparam int AW = 5;
  localparam int DW = 32;
  localparam int SLOW = 8;
  localparam int FAST = 2;
  localparam int WIN = 100;

  typedef struct packed {
    logic [1:0] act;
    logic [7:0] p1;
    logic [7:0] p2;
    logic       fast;
    logic       roff;
    logic       fr;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd0, 8'd3, 8'd2, 1'b1, 1'b0, 1'b0},
    '{2'd2, 8'd1, 8'd4, 1'b0, 1'b0, 1'b0},
    '{2'd3, 8'd0, 8'd0, 1'b1, 1'b0, 1'b0},
    '{2'd1, 8'd2, 8'd1, 1'b0, 1'b1, 1'b0},
    '{2'd0, 8'd1, 8'd1, 1'b1, 1'b0, 1'b1},
    '{2'd2, 8'd0, 8'd0, 1'b0, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1, wr_valid = 1'b0, tick_in = 1'b1;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  wire  [DW-1:0] rd_data;
  wire irq, smi, rreq, prev;

  int n_chk = 0, n_bad = 0, cyc = 0, gen = 0, seen = 0;
  int c_irq = 0, c_smi = 0, c_req = 0, f_irq = -1, f_smi = -1, f_req = -1, dbl = 0;
  logic p_irq = 0, p_smi = 0, p_req = 0;
  bit done = 0;

  wdog_two_stage u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_in(tick_in), .irq_pulse(irq), .smi_pulse(smi),
    .reset_req(rreq), .prev_timeout(prev)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (gen != seen) begin
      seen = gen; c_irq = 0; c_smi = 0; c_req = 0;
      f_irq = -1; f_smi = -1; f_req = -1; dbl = 0;
    end
    if (irq) begin c_irq++; if (f_irq < 0) f_irq = cyc; end
    if (smi) begin c_smi++; if (f_smi < 0) f_smi = cyc; end
    if (rreq) begin c_req++; if (f_req < 0) f_req = cyc; end
    if ((irq && p_irq) || (smi && p_smi) || (rreq && p_req) ||
        (int'(irq) + int'(smi) + int'(rreq) > 1)) dbl++;
    p_irq = irq; p_smi = smi; p_req = rreq;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic wr(input int a, input longint d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic rd(input int a, output longint d);
    @(negedge clk);
    rd_addr = AW'(a); #1;
    d = longint'(rd_data);
  endtask

  task automatic unlock();
    wr('h0C, 'h80);
    wr('h0C, 'h86);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) begin @(posedge clk); #1; end
    @(negedge clk); #1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    longint d;
    int t0, tr, dv, n1, n2, k, er;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    rd('h00, d); chk("R1 pre1 reset", d, 'hFFFFF);
    rd('h04, d); chk("R1 pre2 reset", d, 'hFFFFF);
    rd('h10, d); chk("R1 ctrl reset", d, 0);
    rd('h14, d); chk("R1 lock reset", d, 0);
    rd('h08, d); chk("R1 status reset", d, 0);
    chk("R1 pulses low", {irq, smi, rreq}, 0);

    // R2/R3: key sequence
    wr('h00, 5);
    rd('h00, d); chk("R2 no key ignored", d, 'hFFFFF);
    wr('h0C, 'h86); wr('h00, 5);
    rd('h00, d); chk("R2 open without arm ignored", d, 'hFFFFF);
    unlock(); wr('h00, 'hABC12345);
    rd('h00, d); chk("R3 preload low 20 bits", d, 'h12345);
    wr('h00, 7);
    rd('h00, d); chk("R2 key used up", d, 'h12345);

    // table of configurations: R4 R5 R6 R7 R8 R10 R12
    for (int i = 0; i < 6; i++) begin
      do_reset();
      unlock(); wr('h0C, 'h200);
      chk("R10 flag cleared by bit 9", prev, 0);
      unlock(); wr('h00, VEC[i].p1);
      unlock(); wr('h04, VEC[i].p2);
      wr('h10, (longint'(VEC[i].roff) << 5) | (longint'(VEC[i].fast) << 2) | VEC[i].act);
      wr('h14, (longint'(VEC[i].fr) << 2) | 2);
      t0 = cyc; gen++;
      wait_to(t0 + WIN);
      dv = VEC[i].fast ? FAST : SLOW;
      n1 = (int'(VEC[i].p1) + 1) * dv;
      n2 = (int'(VEC[i].p2) + 1) * dv;
      if (VEC[i].fr) begin
        k = (n1 <= WIN) ? (WIN - n1) / (n1 + n2) + 1 : 0;
        er = 0;
      end else begin
        k = (n1 <= WIN) ? 1 : 0;
        er = (!VEC[i].roff && (n1 + n2 <= WIN)) ? 1 : 0;
      end
      chk($sformatf("R5 vec%0d irq count", i), c_irq, (VEC[i].act == 0) ? k : 0);
      chk($sformatf("R5 vec%0d smi count", i), c_smi, (VEC[i].act == 2) ? k : 0);
      chk($sformatf("R6/R7/R8 vec%0d reset count", i), c_req, er);
      if (VEC[i].act == 0 && k > 0) chk($sformatf("R4 vec%0d irq time", i), f_irq - t0, n1);
      if (VEC[i].act == 2 && k > 0) chk($sformatf("R4 vec%0d smi time", i), f_smi - t0, n1);
      if (er == 1) chk($sformatf("R6 vec%0d reset time", i), f_req - t0, n1 + n2);
      chk($sformatf("R12 vec%0d single pulses", i), dbl, 0);
      chk($sformatf("R6 vec%0d flag", i), prev, er);
      rd('h08, d); chk($sformatf("R10 vec%0d status", i), d, er ? 'h1200 : 0);
    end

    // R9: refresh mid stage 1
    do_reset();
    unlock(); wr('h00, 3);
    wr('h14, 2); t0 = cyc; gen++;
    wait_to(t0 + 20);
    unlock(); wr('h0C, 'h100); tr = cyc;
    wait_to(tr + 40);
    chk("R9 refresh delays irq", f_irq, tr + 32);
    chk("R9 one irq", c_irq, 1);

    // R11: lock freezes enable
    do_reset();
    unlock(); wr('h00, 2);
    wr('h14, 3); t0 = cyc; gen++;
    wr('h14, 0);
    rd('h14, d); chk("R11 enable frozen by lock", d, 3);
    wait_to(t0 + 30);
    chk("R11 locked count continues", f_irq, t0 + 24);

    // R11: disable halts
    do_reset();
    unlock(); wr('h00, 2);
    wr('h14, 2); t0 = cyc; gen++;
    wait_to(t0 + 5);
    wr('h14, 0);
    wait_to(t0 + 60);
    chk("R11 disable halts", c_irq + c_smi + c_req, 0);
    rd('h14, d); chk("R11 enable cleared", d, 0);

    // R10 / R1: flag survives reset, cleared by bit 12
    do_reset();
    unlock(); wr('h00, 0);
    unlock(); wr('h04, 0);
    wr('h10, 4);
    wr('h14, 2); t0 = cyc; gen++;
    wait_to(t0 + 10);
    chk("R6 fast reset time", f_req - t0, 4);
    chk("R6 flag set", prev, 1);
    wr('h0C, 'h200);
    rd('h08, d); chk("R2 clear without key ignored", d, 'h1200);
    do_reset();
    chk("R1 flag survives reset", prev, 1);
    rd('h14, d); chk("R1 lock cleared by reset", d, 0);
    unlock(); wr('h0C, 'h1000);
    rd('h08, d); chk("R10 bit 12 clears status", d, 0);
    chk("R10 flag output clear", prev, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule